// File: doc/BRIEF.md
# Resizable Out-of-Order Issue Queue

This block holds dispatched instructions until their source operands are available and then sends them to execution one at a time. Each instruction arrives with two source tags, a ready flag for each, and a destination tag. A result-tag broadcast sets the ready flag of every waiting source that carries that tag. The destination tag of the instruction issued in a cycle is broadcast inside the queue in the same cycle. A dependent instruction can therefore issue in the very next cycle.

The number of usable entries can be changed at runtime in groups of 16, from 16 up to 128. The size code `n` on the configuration port stands for `(n+1)*16` entries. Selection runs through a tree of 4-input priority encoders. Encoders whose span lies wholly above the active size are switched off, and the root is taken from the lowest tree level that covers the active entries. Growing takes effect on the next clock. Shrinking first stops dispatch and waits until every entry above the new limit has issued; only then is the smaller size committed. The committed size can be read back, saved, and written again later, as an operating system would do at a context switch.

Top module: `rsz_issue_queue`

## Requirements
- R1: After reset the queue is empty, `issue_valid` and `resize_done` are 0, `disp_full` and `resize_busy` are 0, and `cfg_size_rd` reads 7 (128 entries).
- R2: Only an entry whose two ready flags are both set can issue, at most one per cycle. Among ready entries the one with the lowest slot index wins, and the issue port reports that entry's slot and tags. An instruction dispatched with both sources ready appears on the issue port in the cycle after its dispatch cycle.
- R3: A waiting entry is never issued. A broadcast on `wake_valid`/`wake_tag` that matches a pending source marks it ready, and the entry can issue in the cycle after the broadcast.
- R4: When an entry's last pending source equals the destination tag of the instruction issuing in some cycle, that entry can issue in the following cycle.
- R5: A dispatched source whose tag matches a broadcast in the same cycle is stored as ready.
- R6: A dispatch goes into the lowest free slot inside the active size. `disp_full` is 1 when no such slot is free, and a dispatch presented while `disp_full` is 1 is dropped.
- R7: When the size is reduced while entries above the new limit are in use, `resize_busy` and `disp_full` go to 1 in the cycle after the write and `cfg_size_rd` keeps the old value. The doomed entries keep issuing. The new size shows on `cfg_size_rd`, together with a one-cycle `resize_done` pulse, two cycles after the last doomed entry was issued.
- R8: A size reduction whose doomed region is already empty shows `resize_busy` in the cycle after the write, and shows the new size with `resize_done` one cycle later.
- R9: A size increase shows the new size and a `resize_done` pulse in the cycle after the write, with no drain, and the added entries start out free.
- R10: Writing back a value previously read from `cfg_size_rd` restores that size, following R8 or R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_src1 | input | 7 | First source tag |
| disp_src1_rdy | input | 1 | First source already available |
| disp_src2 | input | 7 | Second source tag |
| disp_src2_rdy | input | 1 | Second source already available |
| disp_dst | input | 7 | Destination tag |
| disp_full | output | 1 | No free slot in the active size, or a shrink is pending |
| wake_valid | input | 1 | Result-tag broadcast valid |
| wake_tag | input | 7 | Broadcast tag |
| issue_valid | output | 1 | An entry is being issued this cycle |
| issue_slot | output | 7 | Slot index of the issued entry |
| issue_dst | output | 7 | Destination tag of the issued entry |
| issue_src1 | output | 7 | First source tag of the issued entry |
| issue_src2 | output | 7 | Second source tag of the issued entry |
| cfg_wr | input | 1 | Size write strobe |
| cfg_size | input | 3 | Requested size code, entries = (code+1)*16 |
| cfg_size_rd | output | 3 | Committed size code |
| resize_busy | output | 1 | Shrink waiting for its region to drain |
| resize_done | output | 1 | One-cycle pulse when a new size is committed |

## Verification
The issue outputs depend only on stored state. A ready dispatch presented before edge k is therefore issued in the cycle that follows edge k, and an entry woken at edge k, by a broadcast or by an issuing producer, is issued in that same following cycle. Size reports are due one cycle after a grow and two cycles after an empty-region shrink. A draining shrink lands two cycles after its last doomed issue. The bench drives on falling edges and samples on falling edges, at the exact cycle counts above. A scoreboard of expected destination tags is pushed when the stimulus that makes an entry ready is applied, and popped by a monitor on every issue. Any extra, missing or reordered issue is therefore caught, including a dispatch that should have been dropped.

// File: rtl/iq_pkg.sv
package iq_pkg;

    typedef enum logic {
        SZ_STEADY = 1'b0,
        SZ_DRAIN  = 1'b1
    } iq_phase_e;

    function automatic int unsigned iq_pow4(input int unsigned e);
        int unsigned r;
        r = 1;
        for (int unsigned k = 0; k < e; k++) r = r * 4;
        return r;
    endfunction

    function automatic int unsigned iq_log4_ceil(input int unsigned n);
        int unsigned l;
        int unsigned c;
        l = 0;
        c = 1;
        while (c < n) begin
            c = c * 4;
            l = l + 1;
        end
        return l;
    endfunction

endpackage

// File: rtl/iq_sel_level.sv
module iq_sel_level #(
    parameter int unsigned N_OUT = 1,
    parameter int unsigned IDX_W = 7
) (
    input  logic [N_OUT-1:0]                 node_en,
    input  logic [4*N_OUT-1:0]               req_in,
    input  logic [4*N_OUT-1:0][IDX_W-1:0]    idx_in,
    output logic [N_OUT-1:0]                 req_out,
    output logic [N_OUT-1:0][IDX_W-1:0]      idx_out
);

    // One 4-input priority encoder per node; child 0 has highest priority.
    always_comb begin
        for (int n = 0; n < int'(N_OUT); n++) begin
            req_out[n] = 1'b0;
            idx_out[n] = '0;
            if (node_en[n]) begin
                for (int c = 3; c >= 0; c--) begin
                    if (req_in[4*n+c]) begin
                        req_out[n] = 1'b1;
                        idx_out[n] = idx_in[4*n+c];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/iq_size_ctrl.sv
module iq_size_ctrl
    import iq_pkg::*;
#(
    parameter int unsigned NGROUPS = 8,
    parameter int unsigned SZ_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [SZ_W-1:0]    cfg_size,
    input  logic [NGROUPS-1:0] grp_busy,
    output logic [SZ_W-1:0]    size_q,
    output logic               draining,
    output logic               done
);

    typedef struct packed {
        logic [SZ_W-1:0] size;
        logic [SZ_W-1:0] tgt;
        iq_phase_e       phase;
        logic            done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic tgt_drained;

    always_comb begin
        tgt_drained = 1'b1;
        for (int g = 0; g < int'(NGROUPS); g++) begin
            if (g > int'(ctl_q.tgt) && grp_busy[g]) tgt_drained = 1'b0;
        end

        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (cfg_wr) begin
            if (cfg_size >= ctl_q.size) begin
                ctl_d.size  = cfg_size;
                ctl_d.tgt   = cfg_size;
                ctl_d.phase = SZ_STEADY;
                ctl_d.done  = 1'b1;
            end else begin
                ctl_d.tgt   = cfg_size;
                ctl_d.phase = SZ_DRAIN;
            end
        end else if (ctl_q.phase == SZ_DRAIN && tgt_drained) begin
            ctl_d.size  = ctl_q.tgt;
            ctl_d.phase = SZ_STEADY;
            ctl_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.size  <= SZ_W'(NGROUPS - 1);
            ctl_q.tgt   <= SZ_W'(NGROUPS - 1);
            ctl_q.phase <= SZ_STEADY;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign size_q   = ctl_q.size;
    assign draining = (ctl_q.phase == SZ_DRAIN);
    assign done     = ctl_q.done;

    AST_SIZE_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q.size) |-> ctl_q.done);  // R9

    AST_COMMIT_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_q.phase) == SZ_DRAIN && ctl_q.phase == SZ_STEADY && !$past(cfg_wr))
        |-> (ctl_q.done && ((grp_busy >> (int'(ctl_q.size) + 1)) == '0)));  // R7

endmodule

// File: rtl/rsz_issue_queue.sv
module rsz_issue_queue
    import iq_pkg::*;
#(
    parameter int unsigned TAG_W    = 7,
    parameter int unsigned GROUP_SZ = 16,
    parameter int unsigned NGROUPS  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         disp_valid,
    input  logic [TAG_W-1:0]             disp_src1,
    input  logic                         disp_src1_rdy,
    input  logic [TAG_W-1:0]             disp_src2,
    input  logic                         disp_src2_rdy,
    input  logic [TAG_W-1:0]             disp_dst,
    output logic                         disp_full,
    input  logic                         wake_valid,
    input  logic [TAG_W-1:0]             wake_tag,
    output logic                         issue_valid,
    output logic [$clog2(GROUP_SZ*NGROUPS)-1:0] issue_slot,
    output logic [TAG_W-1:0]             issue_dst,
    output logic [TAG_W-1:0]             issue_src1,
    output logic [TAG_W-1:0]             issue_src2,
    input  logic                         cfg_wr,
    input  logic [$clog2(NGROUPS)-1:0]   cfg_size,
    output logic [$clog2(NGROUPS)-1:0]   cfg_size_rd,
    output logic                         resize_busy,
    output logic                         resize_done
);

    localparam int unsigned NENT   = GROUP_SZ * NGROUPS;
    localparam int unsigned IDX_W  = $clog2(NENT);
    localparam int unsigned SZ_W   = $clog2(NGROUPS);
    localparam int unsigned LEVELS = iq_log4_ceil(NENT);
    localparam int unsigned LEAVES = iq_pow4(LEVELS);

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] src1;
        logic             rdy1;
        logic [TAG_W-1:0] src2;
        logic             rdy2;
        logic [TAG_W-1:0] dst;
    } slot_t;

    typedef struct packed {
        slot_t [NENT-1:0] e;
    } iq_state_t;

    iq_state_t state_d, state_q;

    logic [SZ_W-1:0]    size_q;
    logic               draining;
    logic [NGROUPS-1:0] grp_busy;
    int                 act_ent_int;
    logic               free_any;
    logic [IDX_W-1:0]   free_slot;
    logic [LEAVES-1:0]  leaf_req;
    logic               root_v [LEVELS];
    logic [IDX_W-1:0]   root_i [LEVELS];
    logic               sel_v;
    logic [IDX_W-1:0]   sel_idx;
    logic [TAG_W-1:0]   sel_dst;

    assign act_ent_int = (int'(size_q) + 1) * int'(GROUP_SZ);

    // ---------------- size control ----------------
    iq_size_ctrl #(
        .NGROUPS (NGROUPS),
        .SZ_W    (SZ_W)
    ) u_size (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_size (cfg_size),
        .grp_busy (grp_busy),
        .size_q   (size_q),
        .draining (draining),
        .done     (resize_done)
    );

    always_comb begin
        for (int g = 0; g < int'(NGROUPS); g++) begin
            grp_busy[g] = 1'b0;
            for (int k = 0; k < int'(GROUP_SZ); k++) begin
                grp_busy[g] = grp_busy[g] | state_q.e[g*int'(GROUP_SZ)+k].vld;
            end
        end
    end

    // ---------------- free-slot search ----------------
    always_comb begin
        free_any  = 1'b0;
        free_slot = '0;
        for (int i = int'(NENT) - 1; i >= 0; i--) begin
            if (!state_q.e[i].vld && i < act_ent_int) begin
                free_any  = 1'b1;
                free_slot = IDX_W'(i);
            end
        end
    end

    assign disp_full = !free_any || draining;

    // ---------------- select tree ----------------
    always_comb begin
        leaf_req = '0;
        for (int i = 0; i < int'(NENT); i++) begin
            leaf_req[i] = state_q.e[i].vld && state_q.e[i].rdy1 &&
                          state_q.e[i].rdy2 && (i < act_ent_int);
        end
    end

    for (genvar lv = 0; lv < int'(LEVELS); lv++) begin : g_lvl
        localparam int unsigned NOUT = LEAVES >> (2 * (lv + 1));
        localparam int unsigned SPAN = LEAVES >> (2 * (LEVELS - lv - 1));

        logic [4*NOUT-1:0]             vin;
        logic [4*NOUT-1:0][IDX_W-1:0]  iin;
        logic [NOUT-1:0]               ven;
        logic [NOUT-1:0]               vout;
        logic [NOUT-1:0][IDX_W-1:0]    iout;

        if (lv == 0) begin : g_leaf
            assign vin = leaf_req;
            always_comb begin
                for (int i = 0; i < int'(4*NOUT); i++) iin[i] = IDX_W'(i);
            end
        end else begin : g_inner
            assign vin = g_lvl[lv-1].vout;
            assign iin = g_lvl[lv-1].iout;
        end

        // a node is switched off when its whole span lies above the active size
        always_comb begin
            for (int n = 0; n < int'(NOUT); n++) begin
                ven[n] = (n * int'(SPAN)) < act_ent_int;
            end
        end

        iq_sel_level #(
            .N_OUT (NOUT),
            .IDX_W (IDX_W)
        ) u_lvl (
            .node_en (ven),
            .req_in  (vin),
            .idx_in  (iin),
            .req_out (vout),
            .idx_out (iout)
        );

        assign root_v[lv] = vout[0];
        assign root_i[lv] = iout[0];
    end

    // root is the lowest level whose first node covers the active size
    always_comb begin
        sel_v   = root_v[LEVELS-1];
        sel_idx = root_i[LEVELS-1];
        for (int l = int'(LEVELS) - 1; l >= 0; l--) begin
            if (act_ent_int <= int'(iq_pow4(unsigned'(l + 1)))) begin
                sel_v   = root_v[l];
                sel_idx = root_i[l];
            end
        end
    end

    assign sel_dst     = state_q.e[sel_idx].dst;
    assign issue_valid = sel_v;
    assign issue_slot  = sel_idx;
    assign issue_dst   = sel_dst;
    assign issue_src1  = state_q.e[sel_idx].src1;
    assign issue_src2  = state_q.e[sel_idx].src2;
    assign cfg_size_rd = size_q;
    assign resize_busy = draining;

    // ---------------- next state ----------------
    always_comb begin
        logic hit1;
        logic hit2;
        state_d = state_q;

        if (sel_v) state_d.e[sel_idx].vld = 1'b0;

        for (int i = 0; i < int'(NENT); i++) begin
            if (state_d.e[i].vld) begin
                if ((wake_valid && state_d.e[i].src1 == wake_tag) ||
                    (sel_v && state_d.e[i].src1 == sel_dst))
                    state_d.e[i].rdy1 = 1'b1;
                if ((wake_valid && state_d.e[i].src2 == wake_tag) ||
                    (sel_v && state_d.e[i].src2 == sel_dst))
                    state_d.e[i].rdy2 = 1'b1;
            end
        end

        hit1 = (wake_valid && disp_src1 == wake_tag) || (sel_v && disp_src1 == sel_dst);
        hit2 = (wake_valid && disp_src2 == wake_tag) || (sel_v && disp_src2 == sel_dst);

        if (disp_valid && !disp_full) begin
            state_d.e[free_slot] = '{vld:  1'b1,
                                     src1: disp_src1,
                                     rdy1: disp_src1_rdy | hit1,
                                     src2: disp_src2,
                                     rdy2: disp_src2_rdy | hit2,
                                     dst:  disp_dst};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- assertions ----------------
    AST_ISSUE_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (state_q.e[issue_slot].vld && state_q.e[issue_slot].rdy1 &&
                         state_q.e[issue_slot].rdy2));  // R2

    AST_ISSUE_CLEARS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !state_q.e[$past(issue_slot)].vld);  // R2

    AST_ISSUE_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (int'(issue_slot) < act_ent_int));  // R6

    AST_NONE_ABOVE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_busy >> (int'(size_q) + 1)) == '0));  // R7

    AST_DRAIN_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        resize_busy |-> disp_full);  // R7

endmodule

// File: tb/rsz_issue_queue_tb.sv
module rsz_issue_queue_tb;

    localparam time CLK_P = 20ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_valid = 1'b0;
    logic [6:0] disp_src1 = '0;
    logic       disp_src1_rdy = 1'b0;
    logic [6:0] disp_src2 = '0;
    logic       disp_src2_rdy = 1'b0;
    logic [6:0] disp_dst = '0;
    logic       disp_full;
    logic       wake_valid = 1'b0;
    logic [6:0] wake_tag = '0;
    logic       issue_valid;
    logic [6:0] issue_slot;
    logic [6:0] issue_dst;
    logic [6:0] issue_src1;
    logic [6:0] issue_src2;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_size = '0;
    logic [2:0] cfg_size_rd;
    logic       resize_busy;
    logic       resize_done;

    int checks = 0;
    int fails  = 0;
    int sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    rsz_issue_queue u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .disp_valid    (disp_valid),
        .disp_src1     (disp_src1),
        .disp_src1_rdy (disp_src1_rdy),
        .disp_src2     (disp_src2),
        .disp_src2_rdy (disp_src2_rdy),
        .disp_dst      (disp_dst),
        .disp_full     (disp_full),
        .wake_valid    (wake_valid),
        .wake_tag      (wake_tag),
        .issue_valid   (issue_valid),
        .issue_slot    (issue_slot),
        .issue_dst     (issue_dst),
        .issue_src1    (issue_src1),
        .issue_src2    (issue_src2),
        .cfg_wr        (cfg_wr),
        .cfg_size      (cfg_size),
        .cfg_size_rd   (cfg_size_rd),
        .resize_busy   (resize_busy),
        .resize_done   (resize_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: every issue pops the scoreboard (R2 ordering)
    always @(negedge clk) begin
        if (rst_n && issue_valid) begin
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected issue actual=%0d expected=none", issue_dst);
            end else begin
                int exp_dst;
                exp_dst = sb_q.pop_front();
                if (int'(issue_dst) != exp_dst) begin
                    fails++;
                    $display("FAIL R2 issue order actual=%0d expected=%0d", issue_dst, exp_dst);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic step_disp(input int s1, input bit r1, input int s2, input bit r2, input int d);
        disp_valid    = 1'b1;
        disp_src1     = 7'(s1);
        disp_src1_rdy = r1;
        disp_src2     = 7'(s2);
        disp_src2_rdy = r2;
        disp_dst      = 7'(d);
        @(negedge clk);
        disp_valid    = 1'b0;
    endtask

    task automatic step_wake(input int t);
        wake_valid = 1'b1;
        wake_tag   = 7'(t);
        @(negedge clk);
        wake_valid = 1'b0;
    endtask

    task automatic step_cfg(input int sz);
        cfg_wr   = 1'b1;
        cfg_size = 3'(sz);
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int saved;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk("R1 issue_valid", int'(issue_valid), 0);
        chk("R1 full", int'(disp_full), 0);
        chk("R1 size", int'(cfg_size_rd), 7);
        chk("R1 busy/done", int'({resize_busy, resize_done}), 0);

        // R2 ready dispatches issue the next cycle in order
        sb_q.push_back(10); sb_q.push_back(11); sb_q.push_back(12);
        step_disp(1, 1, 2, 1, 10);
        chk("R2 next-cycle issue", int'(issue_dst), 10);
        step_disp(1, 1, 2, 1, 11);
        step_disp(1, 1, 2, 1, 12);
        tick(3);

        // R3 waiting entry held, released by broadcast
        step_disp(5, 0, 3, 1, 20);
        sb_q.push_back(21);
        step_disp(1, 1, 2, 1, 21);
        tick(3);
        chk("R3 waiting entry held", int'(issue_valid), 0);
        sb_q.push_back(20);
        step_wake(5);
        chk("R3 issue after wake", int'(issue_dst), 20);
        tick(2);

        // R2 lowest index wins when two become ready together
        step_disp(7, 0, 1, 1, 30);
        step_disp(2, 1, 7, 0, 31);
        tick(2);
        sb_q.push_back(30); sb_q.push_back(31);
        step_wake(7);
        chk("R2 lowest slot", int'(issue_slot), 0);
        tick(1);
        chk("R2 second slot", int'(issue_dst), 31);
        tick(2);

        // R4 back-to-back dependent issue
        step_disp(40, 0, 1, 1, 41);
        sb_q.push_back(40); sb_q.push_back(41);
        step_disp(1, 1, 2, 1, 40);
        chk("R4 producer issue", int'(issue_dst), 40);
        tick(1);
        chk("R4 dependent next cycle", int'(issue_valid ? issue_dst : 0), 41);
        tick(2);

        // R5 dispatch-time capture of a same-cycle broadcast
        sb_q.push_back(45);
        wake_valid = 1'b1;
        wake_tag   = 7'd50;
        step_disp(50, 0, 1, 1, 45);
        wake_valid = 1'b0;
        chk("R5 captured wake", int'(issue_valid ? issue_dst : 0), 45);
        tick(2);

        // R8 shrink with empty region: busy next cycle, commit one later
        step_cfg(0);
        chk("R8 busy after write", int'(resize_busy), 1);
        chk("R8 no early done", int'(resize_done), 0);
        tick(1);
        chk("R8 committed size", int'(cfg_size_rd), 0);
        chk("R8 done pulse", int'(resize_done), 1);

        // R6 full at 16 entries, extra dispatch dropped
        for (int i = 0; i < 16; i++) step_disp(60, 0, 1, 1, 100 + i);
        chk("R6 full at 16", int'(disp_full), 1);
        step_disp(1, 1, 2, 1, 99);
        tick(2);
        chk("R6 dropped dispatch", int'(issue_valid), 0);
        for (int i = 0; i < 16; i++) sb_q.push_back(100 + i);
        step_wake(60);
        tick(16);
        chk("R6 all drained", sb_q.size(), 0);

        // R9 grow is immediate, new entries free
        step_cfg(7);
        chk("R9 size after grow", int'(cfg_size_rd), 7);
        chk("R9 done after grow", int'(resize_done), 1);
        for (int i = 0; i < 20; i++) step_disp(61, 0, 1, 1, 64 + i);
        chk("R9 room beyond 16", int'(disp_full), 0);

        // R7 shrink with drain
        step_cfg(0);
        chk("R7 busy", int'(resize_busy), 1);
        chk("R7 stalled", int'(disp_full), 1);
        chk("R7 old size kept", int'(cfg_size_rd), 7);
        step_disp(1, 1, 2, 1, 90);
        for (int i = 0; i < 20; i++) sb_q.push_back(64 + i);
        step_wake(61);
        tick(20);
        chk("R7 not yet done", int'({resize_busy, resize_done}), 2);
        tick(1);
        chk("R7 done", int'(resize_done), 1);
        chk("R7 new size", int'(cfg_size_rd), 0);
        chk("R7 doomed issued", sb_q.size(), 0);

        // R10 save and restore
        saved = int'(cfg_size_rd);
        step_cfg(7);
        chk("R10 grown", int'(cfg_size_rd), 7);
        step_cfg(saved);
        chk("R10 pending", int'(resize_busy), 1);
        tick(1);
        chk("R10 restored", int'(cfg_size_rd), saved);
        chk("R10 done", int'(resize_done), 1);

        tick(3);
        chk("R2 scoreboard empty", sb_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule